// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers per-channel completion and fault events from an eight-channel DMA engine. Each event arrives as a one-cycle pulse. The block holds each event in a sticky status bit until software clears it. A completion event is kept only when the interrupt-request bit of the segment that just finished is set. Fault events are always kept.

Each event class has its own software-writable channel mask. The block ANDs each raw vector with its mask to get a masked vector. It drives a completion interrupt, a fault interrupt and a combined interrupt, each the OR of the matching masked vector.

Software uses a flat register port with a 4-bit address. Reads are combinational and writes take effect on the clock edge. Software can read the raw, masked and combined status views and the channel-enabled vector. Each class has its own write-one-to-clear address.

Top module: `dma_irq_collect`

## Requirements
- R1: After reset, every status bit and both mask registers are 0, and all three interrupt outputs are low.
- R2: A pulse on `tcEvt[i]` while `tcSegIe[i]` is 1 sets raw completion bit i on the next edge. A pulse while `tcSegIe[i]` is 0 leaves that bit unchanged.
- R3: A pulse on `errEvt[i]` sets raw fault bit i on the next edge.
- R4: Reading address 5 returns the raw completion vector and reading address 6 returns the raw fault vector. A 1 means the request is pending.
- R5: Reading address 1 returns raw completion AND completion mask. Reading address 3 returns raw fault AND fault mask.
- R6: Reading address 0 returns, per channel, the OR of the masked completion bit and the masked fault bit.
- R7: Writing to address 2 clears each raw completion bit whose data bit is 1. Data bits of 0 leave their status bits unchanged, and this write has no effect on fault status.
- R8: Writing to address 4 clears each raw fault bit whose data bit is 1. Data bits of 0 leave their status bits unchanged, and this write has no effect on completion status.
- R9: If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: `irqTc` is the OR of the masked completion vector, `irqErr` is the OR of the masked fault vector, and `irqAny` is the OR of the two.
- R11: The completion mask is read and written at address 8, and the fault mask at address 9. A mask bit of 0 suppresses that channel.
- R12: Reading address 7 returns the `chanEn` input. Reading addresses 2 and 4, or any unused address, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tcEvt | input | 8 | Per-channel completion pulses |
| tcSegIe | input | 8 | Per-channel interrupt-request bit of the current segment |
| errEvt | input | 8 | Per-channel fault pulses |
| chanEn | input | 8 | Channel-enabled vector from the engine |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for reads and writes |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| irqTc | output | 1 | Completion interrupt |
| irqErr | output | 1 | Fault interrupt |
| irqAny | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default eight channels. At that width the bench can sweep all 256 values of a counter and derive from it the completion mask, the fault mask, the event vectors, the segment enables and the clear patterns. This covers every mask pattern for both classes and every event/enable pairing on each channel. A separate case drives an event and a clear of the same bit in one cycle, and another confirms that a clear of one class leaves the other class untouched.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic [3:0] {
    ADDR_ANY_STAT = 4'd0,
    ADDR_TC_STAT  = 4'd1,
    ADDR_TC_CLR   = 4'd2,
    ADDR_ERR_STAT = 4'd3,
    ADDR_ERR_CLR  = 4'd4,
    ADDR_TC_RAW   = 4'd5,
    ADDR_ERR_RAW  = 4'd6,
    ADDR_CH_EN    = 4'd7,
    ADDR_TC_MASK  = 4'd8,
    ADDR_ERR_MASK = 4'd9
  } regAddrE;

  localparam int ADDR_W = 4;

  typedef struct packed {
    logic tcClr;
    logic errClr;
    logic tcMaskWr;
    logic errMaskWr;
  } wrStrobeT;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobeT          strb
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regAddr)
        ADDR_TC_CLR:   strb.tcClr     = 1'b1;
        ADDR_ERR_CLR:  strb.errClr    = 1'b1;
        ADDR_TC_MASK:  strb.tcMaskWr  = 1'b1;
        ADDR_ERR_MASK: strb.errMaskWr = 1'b1;
        default:       strb = '0;
      endcase
    end
  end

  // R7 / R8 / R11: a single write never reaches two registers
  always_comb begin
    a_r7_one_strobe: assert ($onehot0(strb));
  end

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobeT          strb,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [NUM_CH-1:0] tcEvt,
  input  logic [NUM_CH-1:0] tcSegIe,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [NUM_CH-1:0] rdData,
  output logic              irqTc,
  output logic              irqErr,
  output logic              irqAny
);

  logic [NUM_CH-1:0] rawTc, rawErr, tcMask, errMask;
  logic [NUM_CH-1:0] tcSet, tcClrVec, errClrVec;
  logic [NUM_CH-1:0] mskTc, mskErr, anyStat;

  assign tcSet     = tcEvt & tcSegIe;
  assign tcClrVec  = strb.tcClr  ? wrData : '0;
  assign errClrVec = strb.errClr ? wrData : '0;

  // event wins over a clear of the same bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawTc   <= '0;
      rawErr  <= '0;
      tcMask  <= '0;
      errMask <= '0;
    end else begin
      rawTc  <= (rawTc  & ~tcClrVec)  | tcSet;
      rawErr <= (rawErr & ~errClrVec) | errEvt;
      if (strb.tcMaskWr)  tcMask  <= wrData;
      if (strb.errMaskWr) errMask <= wrData;
    end
  end

  assign mskTc   = rawTc & tcMask;
  assign mskErr  = rawErr & errMask;
  assign anyStat = mskTc | mskErr;

  assign irqTc  = |mskTc;
  assign irqErr = |mskErr;
  assign irqAny = |anyStat;

  always_comb begin
    case (rdAddr)
      ADDR_ANY_STAT: rdData = anyStat;
      ADDR_TC_STAT:  rdData = mskTc;
      ADDR_ERR_STAT: rdData = mskErr;
      ADDR_TC_RAW:   rdData = rawTc;
      ADDR_ERR_RAW:  rdData = rawErr;
      ADDR_CH_EN:    rdData = chanEn;
      ADDR_TC_MASK:  rdData = tcMask;
      ADDR_ERR_MASK: rdData = errMask;
      default:       rdData = '0;
    endcase
  end

  a_r2_tc_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|tcSet) |=> ((rawTc & $past(tcSet)) == $past(tcSet)));

  a_r2_no_tc_without_ie: assert property (@(posedge clk) disable iff (!rstN)
    ((rawTc & ~$past(rawTc) & ~$past(tcEvt & tcSegIe)) == '0));

  a_r3_err_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|errEvt) |=> ((rawErr & $past(errEvt)) == $past(errEvt)));

  a_r7_tc_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rawTc) & ~rawTc & ~($past(strb.tcClr) ? $past(wrData) : '0)) == '0));

  a_r8_err_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rawErr) & ~rawErr & ~($past(strb.errClr) ? $past(wrData) : '0)) == '0));

  a_r10_any_covers: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqTc | irqErr));

endmodule

// File: rtl/dma_irq_collect.sv
module dma_irq_collect
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tcEvt,
  input  logic [NUM_CH-1:0] tcSegIe,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_CH-1:0] wrData,
  output logic [NUM_CH-1:0] rdData,
  output logic              irqTc,
  output logic              irqErr,
  output logic              irqAny
);

  wrStrobeT strb;

  dma_irq_ctrl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .tcEvt   (tcEvt),
    .tcSegIe (tcSegIe),
    .errEvt  (errEvt),
    .chanEn  (chanEn),
    .rdAddr  (regAddr),
    .rdData  (rdData),
    .irqTc   (irqTc),
    .irqErr  (irqErr),
    .irqAny  (irqAny)
  );

endmodule

// File: tb/sim_dma_irq_collect.sv
module sim_dma_irq_collect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tcEvt = '0, tcSegIe = '0, errEvt = '0, chanEn = '0, wrData = '0;
  logic       wrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] rdData;
  logic       irqTc, irqErr, irqAny;

  int nRun = 0, nFail = 0;
  logic [7:0] eTc = '0, eErr = '0, eTm = '0, eEm = '0;

  always #4 clk = ~clk;

  dma_irq_collect u0 (
    .clk(clk), .rstN(rstN), .tcEvt(tcEvt), .tcSegIe(tcSegIe), .errEvt(errEvt),
    .chanEn(chanEn), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irqTc(irqTc), .irqErr(irqErr), .irqAny(irqAny)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = rdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [7:0] tc, input logic [7:0] ie, input logic [7:0] er);
    @(negedge clk);
    tcEvt = tc; tcSegIe = ie; errEvt = er;
    @(negedge clk);
    tcEvt = '0; tcSegIe = '0; errEvt = '0;
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] v;
    rd(4'd5, v);  chk({"R4 raw tc ", tag}, v, eTc);
    rd(4'd6, v);  chk({"R4 raw err ", tag}, v, eErr);
    rd(4'd1, v);  chk({"R5 masked tc ", tag}, v, eTc & eTm);
    rd(4'd3, v);  chk({"R5 masked err ", tag}, v, eErr & eEm);
    rd(4'd0, v);  chk({"R6 combined ", tag}, v, (eTc & eTm) | (eErr & eEm));
    rd(4'd2, v);  chk({"R12 tc clr reads 0 ", tag}, v, 8'h00);
    rd(4'd4, v);  chk({"R12 err clr reads 0 ", tag}, v, 8'h00);
    rd(4'd7, v);  chk({"R12 chan en ", tag}, v, chanEn);
    chk({"R10 irqTc ", tag}, {7'd0, irqTc}, {7'd0, |(eTc & eTm)});
    chk({"R10 irqErr ", tag}, {7'd0, irqErr}, {7'd0, |(eErr & eEm)});
    chk({"R10 irqAny ", tag}, {7'd0, irqAny}, {7'd0, |((eTc & eTm) | (eErr & eEm))});
  endtask

  initial begin : watchdog
    #1600000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1 reset");
    rd(4'd8, v); chk("R1 tc mask reset", v, 8'h00);
    rd(4'd9, v); chk("R1 err mask reset", v, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    rd(4'd12, v); chk("R12 unused addr", v, 8'h00);

    for (int k = 0; k < 256; k++) begin
      logic [7:0] kk, tc, ie, er, cT, cE;
      kk = 8'(k);
      chanEn = ~kk;
      eTm = kk;
      eEm = {kk[2:0], kk[7:3]} ^ 8'hA5;
      wr(4'd8, eTm);
      wr(4'd9, eEm);
      rd(4'd8, v); chk("R11 tc mask rw", v, eTm);
      rd(4'd9, v); chk("R11 err mask rw", v, eEm);
      tc = kk ^ 8'h5A;
      ie = 8'(k * 37);
      er = (~kk & 8'hC3) | (kk & 8'h14);
      pulse(tc, ie, er);
      eTc |= tc & ie;   // R2: only segments with request bit set
      eErr |= er;       // R3
      checkAll("R2 R3 after events");
      cT = kk ^ 8'h33;
      wr(4'd2, cT);
      eTc &= ~cT;       // R7
      checkAll("R7 after tc clear");
      cE = {kk[4:0], kk[7:5]};
      wr(4'd4, cE);
      eErr &= ~cE;      // R8
      checkAll("R8 after err clear");
    end

    // R7 / R8: full clears leave other class alone
    pulse(8'hFF, 8'hFF, 8'h0F);
    eTc = 8'hFF; eErr |= 8'h0F;
    wr(4'd2, 8'hFF); eTc = 8'h00;
    rd(4'd6, v); chk("R7 tc clear spares err", v, eErr);
    wr(4'd4, 8'hFF); eErr = 8'h00;
    checkAll("R8 all cleared");

    // R9: event and clear collide
    @(negedge clk);
    tcEvt = 8'h21; tcSegIe = 8'h21; errEvt = 8'h84;
    wrEn = 1'b1; regAddr = 4'd2; wrData = 8'hFF;
    @(negedge clk);
    tcEvt = '0; tcSegIe = '0; errEvt = '0; wrData = 8'h84; regAddr = 4'd4;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    rd(4'd5, v); chk("R9 tc event beats clear", v, 8'h21);
    rd(4'd6, v); chk("R8 err cleared after collision", v, 8'h00);

    // R1: reset mid-run clears everything again
    rstN = 1'b0;
    #1;
    eTc = '0; eErr = '0; eTm = '0; eEm = '0;
    checkAll("R1 re-reset");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule